// File: doc/BRIEF.md
# Same-Sign Single-Precision Magnitude Adder

This block sums two IEEE 754 binary32 operands that carry the same sign and returns the rounded binary32 result. Every word uses the standard layout: bit 31 is the sign, bits 30:23 hold the exponent biased by 127, and bits 22:0 hold the fraction without its implicit leading one. An exponent field of all ones marks an infinity when the fraction is zero and a NaN when it is not. The only rounding mode is round to nearest, ties to even. Two flags come with each result. The overflow flag reports exponent overflow. The inexact flag reports that the result differs from the exact sum.

The first stage sorts each operand pair onto one of three paths. Special values (infinity or NaN) take the first. Results that are exact and need no rounding take the second. This covers two subnormals, and it covers two equal normal exponents whose sum has an even significand and stays below exponent 254. All other pairs take the third path: the significands are aligned with a sticky bit and summed into a 31-bit working significand that carries seven low-order extra bits. The second stage rounds that significand. It then packs the word by adding the exponent and the significand rather than OR-ing them, so a carry out of the significand raises the exponent field without separate normalisation logic. The result leaves two cycles after the operands arrive. The caller sends operands of opposite sign to a separate subtraction unit.

Top module: `fp32_mag_adder`

## Requirements
- R1: `res_vld` is high exactly two clock cycles after `op_vld` was sampled high and low otherwise. While reset is held, `res_vld`, `res_word`, `res_ovf` and `res_inx` are all zero.
- R2: When both exponent fields are zero, the result is the 32-bit value formed by adding the zero-extended sum of the two fraction fields to the sign bit placed at bit 31. A carry out of bit 22 therefore yields exponent field 1. Both flags are clear.
- R3: For every result that is not a NaN, bit 31 equals the sign bit of `op_a`.
- R4: If either operand is a NaN, the result is 0x7FC00000 and both flags are clear.
- R5: If neither operand is a NaN and at least one is an infinity, the result is an infinity (exponent 0xFF, fraction 0) whose sign is taken from the infinite operand. Both flags are clear.
- R6: For finite operands that do not overflow, the result is the exact sum rounded to 24 significant bits, nearest first and ties to the value whose fraction bit 0 is 0.
- R7: For finite operands, `res_inx` is 1 exactly when the returned value differs from the exact sum.
- R8: When the rounded biased exponent reaches 255 or more, the result is an infinity with the operand sign, and both `res_ovf` and `res_inx` are 1. `res_ovf` is 0 for every other result.
- R9: Two operands that both have exponent field 254 overflow to infinity with both flags set, whatever their fractions.
- R10: When the exponents differ by more than the working precision, the larger operand is returned unchanged. `res_inx` is 1 exactly when the smaller operand is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_vld | input | 1 | Operands on `op_a` and `op_b` are valid |
| op_a | input | 32 | First binary32 operand; its sign is the result sign |
| op_b | input | 32 | Second binary32 operand, same sign as `op_a` |
| res_vld | output | 1 | Result valid, two cycles after `op_vld` |
| res_word | output | 32 | Rounded binary32 sum |
| res_ovf | output | 1 | Exponent overflow; result forced to infinity |
| res_inx | output | 1 | Result differs from the exact sum |

## Verification
On every cycle the bound checker enforces four things against the inputs from two cycles earlier: the fixed latency, the NaN and infinity results, the direct fraction sum of two subnormals, and the result sign. It also requires that an overflow always arrives as an infinity with the inexact flag set. Correct rounding cannot be captured in a property, so it is checked only by the bench's scenarios. These include ties to even, the carry that bumps the exponent during packing, the 254-exponent overflow, and operands whose exponents lie too far apart to interact. The bench computes the exact sum with wide integers and rounds it independently.

// File: rtl/fp32_mag_pkg.sv
package fp32_mag_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int GRD_W  = 7;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + GRD_W + 1;

  // Which stage-two treatment a captured operand pair needs.
  typedef enum logic [1:0] {
    PATH_SPECIAL = 2'd0,
    PATH_EXACT   = 2'd1,
    PATH_ROUND   = 2'd2
  } path_e;

endpackage

// File: rtl/fp32_mag_special.sv
// Detects infinity and NaN operands and forms their fixed result.
module fp32_mag_special #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opa,
  input  logic [EXP_W+FRAC_W:0] opb,
  output logic                  hit,
  output logic [EXP_W+FRAC_W:0] word
);

  localparam int MSB = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_a, exp_b;
  logic [FRAC_W-1:0] frc_a, frc_b;
  logic              top_a, top_b, nan_any, inf_sign;

  assign exp_a = opa[MSB-1 -: EXP_W];
  assign exp_b = opb[MSB-1 -: EXP_W];
  assign frc_a = opa[FRAC_W-1:0];
  assign frc_b = opb[FRAC_W-1:0];

  assign top_a   = &exp_a;
  assign top_b   = &exp_b;
  assign nan_any = (top_a && (|frc_a)) || (top_b && (|frc_b));
  assign hit     = top_a || top_b;

  // The sign comes from whichever operand is the infinity.
  assign inf_sign = top_a ? opa[MSB] : opb[MSB];

  always_comb begin
    if (nan_any) begin
      word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    end else begin
      word = {inf_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end
  end

endmodule

// File: rtl/fp32_mag_align_sum.sv
// Sorts a finite operand pair onto the exact or the rounding path and
// produces either the finished word or a working significand with extra bits.
module fp32_mag_align_sum #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRD_W  = 7
) (
  input  logic [EXP_W+FRAC_W:0]       opa,
  input  logic [EXP_W+FRAC_W-1:0]     mag_b,
  output logic                        exact_ok,
  output logic [EXP_W+FRAC_W:0]       exact_word,
  output logic [EXP_W-1:0]            exp_base,
  output logic [FRAC_W+GRD_W:0]       sig
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + GRD_W + 1;
  localparam int SHW    = $clog2(SIG_W);
  localparam int PAD_W  = WORD_W - FRAC_W - 1;
  localparam logic [EXP_W-1:0] EXP_NEAR_TOP = {{(EXP_W-1){1'b1}}, 1'b0};
  localparam logic [EXP_W-1:0] SIG_SPAN     = EXP_W'(SIG_W);
  localparam logic [SIG_W-1:0] HIDDEN_ONE   = {2'b01, {(SIG_W-2){1'b0}}};

  logic              sgn, swap;
  logic [EXP_W-1:0]  exp_a, exp_b, exp_l, exp_s, diff;
  logic [FRAC_W-1:0] frc_a, frc_b, frc_l, frc_s;
  logic [FRAC_W:0]   sub_sum;
  logic [FRAC_W+1:0] eq_sum;
  logic [SIG_W-1:0]  sig_big, sig_small, sig_jam, mag_sum, lost_mask;

  assign sgn   = opa[WORD_W-1];
  assign exp_a = opa[WORD_W-2 -: EXP_W];
  assign exp_b = mag_b[WORD_W-2 -: EXP_W];
  assign frc_a = opa[FRAC_W-1:0];
  assign frc_b = mag_b[FRAC_W-1:0];

  assign swap  = exp_b > exp_a;
  assign exp_l = swap ? exp_b : exp_a;
  assign exp_s = swap ? exp_a : exp_b;
  assign frc_l = swap ? frc_b : frc_a;
  assign frc_s = swap ? frc_a : frc_b;
  assign diff  = exp_l - exp_s;

  // Equal-exponent sums: plain fraction sum, and sum with both hidden ones.
  assign sub_sum = {1'b0, frc_a} + {1'b0, frc_b};
  assign eq_sum  = {1'b1, {(FRAC_W+1){1'b0}}} + {2'b00, frc_a} + {2'b00, frc_b};

  // Larger operand's hidden one is added separately with HIDDEN_ONE.
  assign sig_big = {2'b00, frc_l, {(GRD_W-1){1'b0}}};

  // A subnormal smaller operand is doubled to sit at effective exponent 1.
  always_comb begin
    if (exp_s != '0) begin
      sig_small = {2'b01, frc_s, {(GRD_W-1){1'b0}}};
    end else begin
      sig_small = {1'b0, frc_s, {GRD_W{1'b0}}};
    end
  end

  // Right shift with every discarded bit collapsed into bit 0.
  always_comb begin
    lost_mask = ~({SIG_W{1'b1}} << diff[SHW-1:0]);
    if (diff >= SIG_SPAN) begin
      sig_jam = {{(SIG_W-1){1'b0}}, |sig_small};
    end else begin
      sig_jam = (sig_small >> diff[SHW-1:0])
              | {{(SIG_W-1){1'b0}}, |(sig_small & lost_mask)};
    end
  end

  assign mag_sum = HIDDEN_ONE + sig_big + sig_jam;

  always_comb begin
    exact_ok   = 1'b0;
    exact_word = '0;
    exp_base   = exp_l;
    sig        = mag_sum;
    if (exp_a == exp_b) begin
      if (exp_a == '0) begin
        // Carry out of the fraction lands in the exponent field by addition.
        exact_ok   = 1'b1;
        exact_word = {sgn, {(WORD_W-1){1'b0}}} + {{PAD_W{1'b0}}, sub_sum};
      end else begin
        exp_base = exp_a;
        sig      = {eq_sum, {(GRD_W-1){1'b0}}};
        if (!eq_sum[0] && (exp_a < EXP_NEAR_TOP)) begin
          exact_ok   = 1'b1;
          exact_word = {sgn, exp_a, {FRAC_W{1'b0}}}
                     + {{PAD_W{1'b0}}, eq_sum[FRAC_W+1:1]};
        end
      end
    end else if (!mag_sum[SIG_W-1]) begin
      exp_base = exp_l - 1'b1;
      sig      = mag_sum << 1;
    end
  end

endmodule

// File: rtl/fp32_mag_round_pack.sv
// Rounds the working significand to nearest-even and packs by addition.
module fp32_mag_round_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRD_W  = 7
) (
  input  logic                    sign,
  input  logic [EXP_W-1:0]        exp_base,
  input  logic [FRAC_W+GRD_W:0]   sig,
  output logic [EXP_W+FRAC_W:0]   word,
  output logic                    ovf,
  output logic                    inx
);

  localparam int SIG_W = FRAC_W + GRD_W + 1;
  localparam int Q_W   = SIG_W + 1 - GRD_W;
  localparam int PK_W  = EXP_W + FRAC_W + 2;
  localparam logic [SIG_W:0]   HALF_ULP = (SIG_W+1)'(1) << (GRD_W-1);
  localparam logic [GRD_W-1:0] TIE_PAT  = {1'b1, {(GRD_W-1){1'b0}}};
  localparam logic [EXP_W+1:0] EXP_LIM  = {2'b00, {EXP_W{1'b1}}};

  logic [SIG_W:0]   biased;
  logic [GRD_W-1:0] rbits;
  logic             tie;
  logic [Q_W-1:0]   q, q_rne;
  logic [PK_W-1:0]  packed_sum;

  assign rbits  = sig[GRD_W-1:0];
  assign tie    = (rbits == TIE_PAT);
  assign biased = {1'b0, sig} + HALF_ULP;
  assign q      = biased[SIG_W:GRD_W];
  assign q_rne  = {q[Q_W-1:1], q[0] & ~tie};

  // Significand bit 23 and above ripple into the exponent field.
  assign packed_sum = {2'b00, exp_base, {FRAC_W{1'b0}}}
                    + {{(PK_W-Q_W){1'b0}}, q_rne};

  assign ovf = packed_sum[PK_W-1 -: EXP_W+2] >= EXP_LIM;
  assign inx = (|rbits) || ovf;

  always_comb begin
    if (ovf) begin
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      word = {sign, packed_sum[EXP_W+FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fp32_mag_adder.sv
// Two-stage same-sign binary32 adder: classify and align, then round and pack.
module fp32_mag_adder
  import fp32_mag_pkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W,
  parameter int GRD_BITS  = GRD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_vld,
  input  logic [EXP_BITS+FRAC_BITS:0]   op_a,
  input  logic [EXP_BITS+FRAC_BITS:0]   op_b,
  output logic                          res_vld,
  output logic [EXP_BITS+FRAC_BITS:0]   res_word,
  output logic                          res_ovf,
  output logic                          res_inx
);

  localparam int WRD_W = 1 + EXP_BITS + FRAC_BITS;
  localparam int SG_W  = FRAC_BITS + GRD_BITS + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Stage one combinational results.
  logic             spec_hit, exact_ok;
  logic [WRD_W-1:0] spec_word, exact_word;
  logic [EXP_BITS-1:0] exp_base_d;
  logic [SG_W-1:0]  sig_d;

  fp32_mag_special #(.EXP_W(EXP_BITS), .FRAC_W(FRAC_BITS)) u_special (
    .opa  (op_a),
    .opb  (op_b),
    .hit  (spec_hit),
    .word (spec_word)
  );

  fp32_mag_align_sum #(.EXP_W(EXP_BITS), .FRAC_W(FRAC_BITS), .GRD_W(GRD_BITS)) u_align (
    .opa        (op_a),
    .mag_b      (op_b[WRD_W-2:0]),
    .exact_ok   (exact_ok),
    .exact_word (exact_word),
    .exp_base   (exp_base_d),
    .sig        (sig_d)
  );

  path_e            kind_d;
  logic [WRD_W-1:0] word_d;

  always_comb begin
    if (spec_hit) begin
      kind_d = PATH_SPECIAL;
      word_d = spec_word;
    end else if (exact_ok) begin
      kind_d = PATH_EXACT;
      word_d = exact_word;
    end else begin
      kind_d = PATH_ROUND;
      word_d = exact_word;
    end
  end

  // Stage one registers.
  logic                s1_vld;
  path_e               s1_kind;
  logic                s1_sign;
  logic [WRD_W-1:0]    s1_word;
  logic [EXP_BITS-1:0] s1_exp;
  logic [SG_W-1:0]     s1_sig;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_vld <= 1'b0;
    else             s1_vld <= op_vld;
  end

  always_ff @(posedge clk) begin
    if (op_vld) begin
      s1_kind <= kind_d;
      s1_sign <= op_a[WRD_W-1];
      s1_word <= word_d;
      s1_exp  <= exp_base_d;
      s1_sig  <= sig_d;
    end
  end

  // Stage two: round, pack, select.
  logic [WRD_W-1:0] rp_word;
  logic             rp_ovf, rp_inx;

  fp32_mag_round_pack #(.EXP_W(EXP_BITS), .FRAC_W(FRAC_BITS), .GRD_W(GRD_BITS)) u_round (
    .sign     (s1_sign),
    .exp_base (s1_exp),
    .sig      (s1_sig),
    .word     (rp_word),
    .ovf      (rp_ovf),
    .inx      (rp_inx)
  );

  logic [WRD_W-1:0] res_word_d;
  logic             res_ovf_d, res_inx_d;

  always_comb begin
    if (s1_kind == PATH_ROUND) begin
      res_word_d = rp_word;
      res_ovf_d  = rp_ovf;
      res_inx_d  = rp_inx;
    end else begin
      res_word_d = s1_word;
      res_ovf_d  = 1'b0;
      res_inx_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_vld  <= 1'b0;
      res_word <= '0;
      res_ovf  <= 1'b0;
      res_inx  <= 1'b0;
    end else begin
      res_vld <= s1_vld;
      if (s1_vld) begin
        res_word <= res_word_d;
        res_ovf  <= res_ovf_d;
        res_inx  <= res_inx_d;
      end
    end
  end

endmodule

// File: rtl/fp32_mag_adder_chk.sv
module fp32_mag_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_vld,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        res_vld,
  input logic [31:0] res_word,
  input logic        res_ovf,
  input logic        res_inx
);

  function automatic logic is_nan(input logic [31:0] w);
    return (&w[30:23]) && (|w[22:0]);
  endfunction

  function automatic logic is_inf(input logic [31:0] w);
    return (&w[30:23]) && !(|w[22:0]);
  endfunction

  // Cycles since reset release, saturating; guards looks two cycles back.
  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= 3'd0;
    else if (warm_cnt != 3'd4) warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt == 3'd4);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (res_vld == $past(op_vld, 2)));

  assert_nan_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_vld && $past(op_vld && (is_nan(op_a) || is_nan(op_b)), 2))
    |-> (res_word == 32'h7FC0_0000 && !res_ovf && !res_inx));

  assert_inf_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_vld && $past(op_vld && !is_nan(op_a) && !is_nan(op_b)
                              && (is_inf(op_a) || is_inf(op_b)), 2))
    |-> (res_word == {($past(is_inf(op_a), 2) ? $past(op_a[31], 2) : $past(op_b[31], 2)),
                      8'hFF, 23'h0} && !res_ovf && !res_inx));

  assert_sub_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_vld && $past(op_vld && op_a[30:23] == 8'h00 && op_b[30:23] == 8'h00, 2))
    |-> (res_word == ({$past(op_a[31], 2), 31'h0}
                      + {9'h0, $past(op_a[22:0], 2)}
                      + {9'h0, $past(op_b[22:0], 2)})
         && !res_ovf && !res_inx));

  assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_vld && $past(op_vld && !is_nan(op_a) && !is_nan(op_b)
                              && op_a[31] == op_b[31], 2))
    |-> (res_word[31] == $past(op_a[31], 2)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_ovf) |-> (res_inx && res_word[30:0] == {8'hFF, 23'h0}));

endmodule

bind fp32_mag_adder fp32_mag_adder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_vld   (op_vld),
  .op_a     (op_a),
  .op_b     (op_b),
  .res_vld  (res_vld),
  .res_word (res_word),
  .res_ovf  (res_ovf),
  .res_inx  (res_inx)
);

// File: tb/fp32_mag_adder_test.sv
`timescale 1ns/1ps
module fp32_mag_adder_test;

  logic        clk, rst_n, op_vld;
  logic [31:0] op_a, op_b;
  logic        res_vld, res_ovf, res_inx;
  logic [31:0] res_word;

  fp32_mag_adder uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_vld   (op_vld),
    .op_a     (op_a),
    .op_b     (op_b),
    .res_vld  (res_vld),
    .res_word (res_word),
    .res_ovf  (res_ovf),
    .res_inx  (res_inx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] a;
    logic [31:0] res;
    logic        ovf;
    logic        inx;
    logic        nan;
    int          tag;
    longint      due;
  } exp_t;

  exp_t pend[$];

  function automatic string tag_name(input int t);
    case (t)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input bit ok, input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag_name(tag), act, exp);
    end
  endtask

  // Exact sum by wide integer arithmetic, then nearest-even rounding.
  // Returns {ovf, inx, word}.
  function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic         s;
    int           xa, xb, xl, xs, gap, p, sh;
    logic [127:0] ma, mb, ml, ms, sum, q, rem, half;
    logic [63:0]  pk;
    logic [31:0]  big;
    s = a[31];
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0))
      return {2'b00, 32'h7FC0_0000};
    if (a[30:23] == 8'hFF) return {2'b00, a[31], 8'hFF, 23'h0};
    if (b[30:23] == 8'hFF) return {2'b00, b[31], 8'hFF, 23'h0};
    xa = (a[30:23] == 0) ? 1 : int'(a[30:23]);
    xb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
    ma = (a[30:23] == 0) ? {105'd0, a[22:0]} : {104'd0, 1'b1, a[22:0]};
    mb = (b[30:23] == 0) ? {105'd0, b[22:0]} : {104'd0, 1'b1, b[22:0]};
    if (xa >= xb) begin
      ml = ma; xl = xa; ms = mb; xs = xb; big = {s, a[30:0]};
    end else begin
      ml = mb; xl = xb; ms = ma; xs = xa; big = {s, b[30:0]};
    end
    gap = xl - xs;
    if (gap > 40) return {1'b0, (ms != 0), big};
    sum = (ml << gap) + ms;
    p = 0;
    for (int k = 0; k < 128; k++) if (sum[k]) p = k;
    if (p <= 23) begin
      pk = (64'(xs - 1) << 23) + sum[63:0];
      return {2'b00, s, pk[30:0]};
    end
    sh   = p - 23;
    q    = sum >> sh;
    rem  = sum & ((128'd1 << sh) - 128'd1);
    half = 128'd1 << (sh - 1);
    if (rem > half || (rem == half && q[0])) q = q + 128'd1;
    pk = (64'(xs - 1 + sh) << 23) + q[63:0];
    if (pk[63:23] >= 41'd255) return {2'b11, s, 8'hFF, 23'h0};
    return {1'b0, (rem != 0), s, pk[30:0]};
  endfunction

  function automatic int classify(input logic [31:0] a, input logic [31:0] b, input logic ovf);
    int ea, eb, gap;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 4;
    if (ea == 255 || eb == 255) return 5;
    if (ea == 0 && eb == 0) return 2;
    if (ea == 254 && eb == 254) return 9;
    gap = (ea > eb) ? ea - eb : eb - ea;
    if (gap > 25) return 10;
    if (ovf) return 8;
    return 6;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b_in);
    logic [31:0] b;
    logic [33:0] m;
    exp_t        e;
    b = {a[31], b_in[30:0]};
    m = ref_add(a, b);
    @(negedge clk);
    op_a   = a;
    op_b   = b;
    op_vld = 1'b1;
    e.a   = a;
    e.res = m[31:0];
    e.ovf = m[33];
    e.inx = m[32];
    e.nan = (m[31:0] == 32'h7FC0_0000);
    e.tag = classify(a, b, m[33]);
    e.due = cyc + 2;
    pend.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_vld = 1'b0;
    end
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_vld) begin
        if (pend.size() == 0) begin
          check(1'b0, 1, 32'(cyc), 32'hFFFF_FFFF);  // R1 unexpected valid
        end else begin
          exp_t e;
          e = pend.pop_front();
          check(e.due == cyc, 1, 32'(cyc), 32'(e.due));          // R1 latency
          check(res_word == e.res, e.tag, res_word, e.res);
          check(res_inx == e.inx, 7, {31'h0, res_inx}, {31'h0, e.inx});  // R7
          check(res_ovf == e.ovf, 8, {31'h0, res_ovf}, {31'h0, e.ovf});  // R8
          if (!e.nan) check(res_word[31] == e.a[31], 3, {31'h0, res_word[31]}, {31'h0, e.a[31]}); // R3
        end
      end else if (pend.size() > 0 && pend[0].due <= cyc) begin
        check(1'b0, 1, 32'(cyc), 32'(pend[0].due));  // R1 missing valid
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R1: watchdog expired, actual %0d pending expected 0", pend.size());
      summary();
      $finish;
    end
  end

  initial begin
    int issued;
    rst_n  = 1'b0;
    op_vld = 1'b0;
    op_a   = '0;
    op_b   = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(res_vld == 1'b0, 1, {31'h0, res_vld}, 32'h0);
    check(res_word == 32'h0 && !res_ovf && !res_inx, 1, res_word, 32'h0);
    rst_n = 1'b1;
    idle(6);

    // Directed corners.
    issue(32'h0040_0000, 32'h0040_0000);  // R2 carry to exponent 1
    issue(32'h007F_FFFF, 32'h0000_0001);  // R2
    issue(32'h8000_0003, 32'h8000_0005);  // R2 negative
    issue(32'h7F00_0000, 32'h7F00_0000);  // R9
    issue(32'h7F7F_FFFF, 32'h7F7F_FFFF);  // R9
    issue(32'h7F7F_FFFF, 32'h7300_0000);  // R8 tie rounds up into overflow
    issue(32'h3F80_0000, 32'h3380_0000);  // R6 tie stays even
    issue(32'h3F80_0001, 32'h3380_0000);  // R6 tie rounds up
    issue(32'h3F80_0000, 32'h3F80_0000);  // R6 exact equal exponents
    issue(32'h7F80_0000, 32'h7F80_0000);  // R5
    issue(32'hFF80_0000, 32'h3F80_0000);  // R5 negative
    issue(32'h3F80_0000, 32'h7F80_0000);  // R5 infinity in b
    issue(32'h7FC0_1234, 32'h3F80_0000);  // R4
    issue(32'h3F80_0000, 32'h7F80_0001);  // R4
    issue(32'h7F00_0000, 32'h0000_0001);  // R10
    issue(32'h4000_0000, 32'h0000_0000);  // R10 exact
    idle(4);

    // Subnormal pairs.
    issued = 0;
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        logic [22:0] fa, fb;
        fa = (i == 63) ? 23'h7F_FFFF : 23'(i * 131071 + i * i * 7);
        fb = (j == 63) ? 23'h7F_FFFF : 23'(j * 96557 + 3 * j);
        issue({1'(i + j), 8'h00, fa}, {1'(i + j), 8'h00, fb});
        issued++;
        if ((issued % 16) == 0) idle(1);
      end
    end

    // Every exponent pair.
    for (int ea = 0; ea < 256; ea++) begin
      for (int eb = 0; eb < 256; eb++) begin
        logic [22:0] fa, fb;
        fa = 23'((ea * 40503) ^ (eb * 7919));
        fb = 23'(eb * 52021 + ea * 313);
        if (ea == 255 && eb[0]) fa = '0;
        if (eb == 255 && ea[0]) fb = '0;
        issue({1'(ea ^ eb), 8'(ea), fa}, {1'(ea ^ eb), 8'(eb), fb});
        issued++;
        if ((issued % 16) == 0) idle(1);
      end
    end

    // Random normal pairs with close exponents.
    for (int n = 0; n < 20000; n++) begin
      int ea, eb;
      ea = 1 + int'($urandom % 254);
      eb = ea - int'($urandom % 30);
      if (eb < 1) eb = 1;
      issue({1'($urandom), 8'(ea), 23'($urandom)}, {1'b0, 8'(eb), 23'($urandom)});
      issued++;
      if ((issued % 16) == 0) idle(1);
    end

    idle(8);
    check(pend.size() == 0, 1, 32'(pend.size()), 32'h0);  // R1 nothing lost
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule